// File: doc/BRIEF.md
# Vector Saturating Rounding Doubling Multiply-Accumulate Unit

This block is the integer datapath for one saturating rounding doubling multiply-accumulate (or multiply-subtract) step on a packed vector register. Every lane takes two signed multiplicands and an accumulator, which is the current contents of the destination lane. The product is merged with the up-shifted accumulator and a rounding constant in a single wide sum. One arithmetic right shift then brings the sum down to lane width, and the value is clamped to the lane's signed range. The result replaces the destination lane.

A 1-bit lane-size select picks eight 16-bit lanes or four 32-bit lanes in the default 128-bit register. A second 1-bit select chooses accumulate or subtract. Each request carries two byte counts, both multiples of 8: the operand size and the maximum register size. Lanes below the operand size are computed. 64-bit chunks from the operand size up to the maximum size are forced to zero. Chunks past the maximum size return the destination value unchanged.

A sticky flag records any saturation in a computed lane and is cleared only by its own clear input. The datapath has two stages, multiply followed by merge/round/clamp, and applies no backpressure. A request may be issued on every cycle.

Top module: `vec_qrdmla_unit`

## Requirements
- R1: With a 16-bit lane select (`lane32`=0) and accumulate mode (`sub_mode`=0), each lane result is floor(((acc·2^15) + a·b + 2^14) / 2^15), computed exactly. Lane i occupies bits [16i+15:16i] of every vector, and a, b and acc are signed two's complement.
- R2: With a 32-bit lane select (`lane32`=1), each lane result is floor(((acc·2^31) ± a·b + 2^30) / 2^31), computed exactly. Lane k occupies bits [32k+31:32k].
- R3: With `sub_mode`=1, the product is subtracted from the shifted accumulator instead of added, for either lane size.
- R4: A value above the lane's signed range is replaced by 0x7FFF or 0x7FFFFFFF. A value below the range is replaced by 0x8000 or 0x80000000.
- R5: Lanes are independent. A saturating or extreme value in one lane does not change any other lane's result.
- R6: `sat_flag` rises in the same cycle as the `out_valid` of an operation in which at least one computed lane saturated. It then stays high while `sat_clear` is low.
- R7: `sat_clear` high at a clock edge drops `sat_flag` to 0. If a saturating result lands at the same edge, the flag is set instead.
- R8: A 64-bit chunk c (bits [64c+63:64c]) is computed when 8c < `opr_bytes`. It is zero when `opr_bytes` ≤ 8c < `max_bytes`. Otherwise it carries the destination input unchanged.
- R9: `out_valid` is high exactly two clock cycles after each cycle in which `in_valid` is sampled high, with back-to-back requests allowed.
- R10: While `rst_n` is sampled low at a clock edge, `out_valid`, `sat_flag` and `result` are cleared to 0.
- R11: `result` holds its value in every cycle in which `out_valid` is low.
- R12: Saturation in a lane that lies in a zeroed or pass-through chunk does not set `sat_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe for the operands on this cycle |
| lane32 | input | 1 | Lane size: 0 = 16-bit lanes, 1 = 32-bit lanes |
| sub_mode | input | 1 | 0 = add product, 1 = subtract product |
| opr_bytes | input | 5 | Operand size in bytes (multiple of 8) |
| max_bytes | input | 5 | Maximum register size in bytes (multiple of 8) |
| src_a | input | 128 | First multiplicand vector |
| src_b | input | 128 | Second multiplicand vector |
| dst_in | input | 128 | Current destination vector, used as accumulators |
| sat_clear | input | 1 | Synchronous clear of the sticky saturation flag |
| out_valid | output | 1 | Result strobe, two cycles after the request |
| result | output | 128 | New destination vector |
| sat_flag | output | 1 | Sticky cumulative-saturation flag |

## Verification
Two events can meet at one clock edge: a saturating result landing (which sets the flag) and a software clear of the flag. The bench issues a request known to saturate, then raises `sat_clear` in exactly the cycle the result arrives. The flag must read 1 afterwards, and a plain clear pulse on a later idle cycle must read 0. Arithmetic is judged against a 64-bit integer model in the bench over all combinations of a set of corner values for both lane sizes and both modes, back-to-back issue, and operand/maximum size mixes.

// File: rtl/qrdm_pkg.sv
// Shared types and constants for the saturating rounding doubling
// multiply-accumulate unit. Assumes vector widths are multiples of 64.
package qrdm_pkg;

    // Lane size select as carried down the pipeline.
    typedef enum logic {
        LANE_HALF = 1'b0,
        LANE_WORD = 1'b1
    } lane_e;

    // Granule for tail zeroing, in bits.
    localparam int CHUNK_BITS = 64;

endpackage

// File: rtl/qrdm_tail_mask.sv
// Decodes operand size and maximum size into per-64-bit-chunk masks.
// keep: the chunk is computed. zero: the chunk is forced to zero.
// Neither: the destination value passes through. Assumes byte counts are
// multiples of 8; a maximum below the operand size is treated as the
// operand size.
module qrdm_tail_mask #(
    parameter int VEC_W = 128
) (
    input  logic [$clog2(VEC_W/8):0]   opr_bytes,
    input  logic [$clog2(VEC_W/8):0]   max_bytes,
    output logic [VEC_W/64-1:0]        keep,
    output logic [VEC_W/64-1:0]        zero
);
    localparam int CH = VEC_W / qrdm_pkg::CHUNK_BITS;
    localparam int BW = $clog2(VEC_W/8) + 1;

    for (genvar c = 0; c < CH; c++) begin : g_chunk
        localparam logic [BW-1:0] BASE = BW'(c * 8);
        // Chunk classification against both byte limits
        assign keep[c] = (opr_bytes > BASE);
        assign zero[c] = !(opr_bytes > BASE) && (max_bytes > BASE);
    end

endmodule

// File: rtl/qrdm_mul_stage.sv
// First pipeline stage: forms every signed 16x16 and 32x32 product of the
// two multiplicand vectors and registers them with the accumulators, the
// controls and the chunk masks. Both lane sizes are computed on every
// request, and stage two selects between them.
module qrdm_mul_stage #(
    parameter int VEC_W = 128
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     lane32,
    input  logic                     sub_mode,
    input  logic [VEC_W/64-1:0]      keep_in,
    input  logic [VEC_W/64-1:0]      zero_in,
    input  logic [VEC_W-1:0]         src_a,
    input  logic [VEC_W-1:0]         src_b,
    input  logic [VEC_W-1:0]         acc_in,
    output logic                     v_q,
    output qrdm_pkg::lane_e          lane_q,
    output logic                     sub_q,
    output logic [VEC_W/64-1:0]      keep_q,
    output logic [VEC_W/64-1:0]      zero_q,
    output logic [VEC_W-1:0]         acc_q,
    output logic [2*VEC_W-1:0]       p16_q,
    output logic [2*VEC_W-1:0]       p32_q
);
    localparam int NL16 = VEC_W / 16;
    localparam int NL32 = VEC_W / 32;
    localparam int CH   = VEC_W / qrdm_pkg::CHUNK_BITS;

    logic [2*VEC_W-1:0] p16_d;
    logic [2*VEC_W-1:0] p32_d;

    for (genvar i = 0; i < NL16; i++) begin : g_m16
        logic signed [15:0] ha;
        logic signed [15:0] hb;
        logic signed [31:0] hp;
        assign ha = src_a[16*i +: 16];
        assign hb = src_b[16*i +: 16];
        // Signed half-lane product
        assign hp = ha * hb;
        assign p16_d[32*i +: 32] = hp;
    end

    for (genvar k = 0; k < NL32; k++) begin : g_m32
        logic signed [31:0] wa;
        logic signed [31:0] wb;
        logic signed [63:0] wp;
        assign wa = src_a[32*k +: 32];
        assign wb = src_b[32*k +: 32];
        // Signed word-lane product
        assign wp = wa * wb;
        assign p32_d[64*k +: 64] = wp;
    end

    // Pipeline register for products, accumulators and controls
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q    <= 1'b0;
            lane_q <= qrdm_pkg::LANE_HALF;
            sub_q  <= 1'b0;
            keep_q <= '0;
            zero_q <= '0;
            acc_q  <= '0;
            p16_q  <= '0;
            p32_q  <= '0;
        end else begin
            v_q <= in_valid;
            if (in_valid) begin
                lane_q <= lane32 ? qrdm_pkg::LANE_WORD : qrdm_pkg::LANE_HALF;
                sub_q  <= sub_mode;
                keep_q <= keep_in[CH-1:0];
                zero_q <= zero_in[CH-1:0];
                acc_q  <= acc_in;
                p16_q  <= p16_d;
                p32_q  <= p32_d;
            end
        end
    end

endmodule

// File: rtl/qrdm_round_sat.sv
// Combinational merge, round, narrow and clamp for one lane of width LW.
// Computes ((acc << (LW-1)) +/- prod + (1 << (LW-2))) >>> (LW-1) in a
// sum two bits wider than the product, then clamps to the signed range
// of LW bits. Assumes LW >= 4.
module qrdm_round_sat #(
    parameter int LW = 16
) (
    input  logic [2*LW-1:0] prod,
    input  logic [LW-1:0]   acc,
    input  logic            sub,
    output logic [LW-1:0]   res,
    output logic            sat
);
    localparam int SW = 2*LW + 2;
    localparam int SH = LW - 1;

    logic signed [SW-1:0] acc_x;
    logic signed [SW-1:0] prod_x;
    logic signed [SW-1:0] rnd;
    logic signed [SW-1:0] shr;
    logic [SW-LW:0]       upper;
    logic                 fits;

    // Operand alignment to the wide sum
    assign acc_x  = {{(SW-LW){acc[LW-1]}}, acc} <<< SH;
    assign prod_x = {{2{prod[2*LW-1]}}, prod};
    assign rnd    = {{(SW-1){1'b0}}, 1'b1} << (SH-1);

    // Single merged sum and narrowing shift
    assign shr = (sub ? (acc_x - prod_x + rnd) : (acc_x + prod_x + rnd)) >>> SH;

    // Range test: the bits above the lane must all equal its sign
    assign upper = shr[SW-1:LW-1];
    assign fits  = (&upper) || !(|upper);
    assign sat   = !fits;

    // Clamp selection toward the sign of the wide value
    always_comb begin
        if (fits) begin
            res = shr[LW-1:0];
        end else if (shr[SW-1]) begin
            res = {1'b1, {(LW-1){1'b0}}};
        end else begin
            res = {1'b0, {(LW-1){1'b1}}};
        end
    end

endmodule

// File: rtl/vec_qrdmla_unit.sv
// Packed-vector saturating rounding doubling multiply-accumulate unit.
// Stage one multiplies, stage two merges the accumulator, rounds, narrows,
// clamps, applies the chunk masks and updates the sticky saturation flag.
// Assumes VEC_W is a multiple of 64 and byte counts are multiples of 8.
module vec_qrdmla_unit #(
    parameter int VEC_W = 128
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic                       lane32,
    input  logic                       sub_mode,
    input  logic [$clog2(VEC_W/8):0]   opr_bytes,
    input  logic [$clog2(VEC_W/8):0]   max_bytes,
    input  logic [VEC_W-1:0]           src_a,
    input  logic [VEC_W-1:0]           src_b,
    input  logic [VEC_W-1:0]           dst_in,
    input  logic                       sat_clear,
    output logic                       out_valid,
    output logic [VEC_W-1:0]           result,
    output logic                       sat_flag
);
    localparam int NL16   = VEC_W / 16;
    localparam int NL32   = VEC_W / 32;
    localparam int CH     = VEC_W / qrdm_pkg::CHUNK_BITS;
    localparam int H_PER  = qrdm_pkg::CHUNK_BITS / 16;
    localparam int W_PER  = qrdm_pkg::CHUNK_BITS / 32;

    logic [CH-1:0]      keep_d, zero_d, keep_q, zero_q;
    logic               v_q, sub_q;
    qrdm_pkg::lane_e    lane_q;
    logic [VEC_W-1:0]   acc_q;
    logic [2*VEC_W-1:0] p16_q, p32_q;
    logic [VEC_W-1:0]   r16, r32, nxt;
    logic [NL16-1:0]    s16, s16_live;
    logic [NL32-1:0]    s32, s32_live;
    logic               hit;

    qrdm_tail_mask #(.VEC_W(VEC_W)) u_tail (
        .opr_bytes (opr_bytes),
        .max_bytes (max_bytes),
        .keep      (keep_d),
        .zero      (zero_d)
    );

    qrdm_mul_stage #(.VEC_W(VEC_W)) u_mul (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .lane32   (lane32),
        .sub_mode (sub_mode),
        .keep_in  (keep_d),
        .zero_in  (zero_d),
        .src_a    (src_a),
        .src_b    (src_b),
        .acc_in   (dst_in),
        .v_q      (v_q),
        .lane_q   (lane_q),
        .sub_q    (sub_q),
        .keep_q   (keep_q),
        .zero_q   (zero_q),
        .acc_q    (acc_q),
        .p16_q    (p16_q),
        .p32_q    (p32_q)
    );

    for (genvar i = 0; i < NL16; i++) begin : g_h
        qrdm_round_sat #(.LW(16)) u_rs (
            .prod (p16_q[32*i +: 32]),
            .acc  (acc_q[16*i +: 16]),
            .sub  (sub_q),
            .res  (r16[16*i +: 16]),
            .sat  (s16[i])
        );
        // Saturation counts only in computed chunks
        assign s16_live[i] = s16[i] && keep_q[i / H_PER];
    end

    for (genvar k = 0; k < NL32; k++) begin : g_w
        qrdm_round_sat #(.LW(32)) u_rs (
            .prod (p32_q[64*k +: 64]),
            .acc  (acc_q[32*k +: 32]),
            .sub  (sub_q),
            .res  (r32[32*k +: 32]),
            .sat  (s32[k])
        );
        // Saturation counts only in computed chunks
        assign s32_live[k] = s32[k] && keep_q[k / W_PER];
    end

    assign hit = (lane_q == qrdm_pkg::LANE_WORD) ? (|s32_live) : (|s16_live);

    // Per-chunk choice among computed, zeroed and pass-through data
    always_comb begin
        for (int c = 0; c < CH; c++) begin
            if (keep_q[c]) begin
                nxt[64*c +: 64] = (lane_q == qrdm_pkg::LANE_WORD) ? r32[64*c +: 64]
                                                                   : r16[64*c +: 64];
            end else if (zero_q[c]) begin
                nxt[64*c +: 64] = '0;
            end else begin
                nxt[64*c +: 64] = acc_q[64*c +: 64];
            end
        end
    end

    // Output register, valid strobe and sticky flag (set beats clear)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            sat_flag  <= 1'b0;
        end else begin
            out_valid <= v_q;
            if (v_q) begin
                result <= nxt;
            end
            sat_flag <= (v_q && hit) || (sat_flag && !sat_clear);
        end
    end

endmodule

// File: rtl/qrdm_checker.sv
// Protocol and flag assertions for vec_qrdmla_unit, attached by bind.
// Uses a cycles-since-reset counter so that no look-back reaches into
// the reset period.
module qrdm_checker #(
    parameter int VEC_W = 128
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic                     sat_clear,
    input logic [$clog2(VEC_W/8):0] opr_bytes,
    input logic [$clog2(VEC_W/8):0] max_bytes,
    input logic                     out_valid,
    input logic [VEC_W-1:0]         result,
    input logic                     sat_flag
);
    logic [1:0] cyc;

    // Saturating count of edges since reset release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc <= 2'd0;
        end else if (cyc != 2'd3) begin
            cyc <= cyc + 2'd1;
        end
    end

    p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    p_flag_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd1 && $rose(sat_flag)) |-> out_valid);

    p_flag_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd1 && $fell(sat_flag)) |-> $past(sat_clear));

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd1 && !out_valid) |-> $stable(result));

    p_all_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd2 && out_valid && $past(opr_bytes, 2) == '0
         && $past(max_bytes, 2) == ($clog2(VEC_W/8)+1)'(VEC_W/8))
        |-> (result == '0));

endmodule

bind vec_qrdmla_unit qrdm_checker #(.VEC_W(VEC_W)) u_qrdm_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .sat_clear (sat_clear),
    .opr_bytes (opr_bytes),
    .max_bytes (max_bytes),
    .out_valid (out_valid),
    .result    (result),
    .sat_flag  (sat_flag)
);

// File: tb/vec_qrdmla_unit_bench.sv
`timescale 1ns/1ps
module vec_qrdmla_unit_bench;
    localparam int VW = 128;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         lane32 = 1'b0;
    logic         sub_mode = 1'b0;
    logic [4:0]   opr_bytes = 5'd16;
    logic [4:0]   max_bytes = 5'd16;
    logic [VW-1:0] src_a = '0, src_b = '0, dst_in = '0;
    logic         sat_clear = 1'b0;
    logic         out_valid;
    logic [VW-1:0] result;
    logic         sat_flag;

    int nchk = 0;
    int nerr = 0;
    bit exp_flag = 1'b0;

    int     v16[8] = '{-32768, -32767, -16384, -1, 0, 1, 16383, 32767};
    longint v32[8] = '{-64'sd2147483648, -64'sd2147483647, -64'sd1073741824, -64'sd1,
                       64'sd0, 64'sd1, 64'sd1073741823, 64'sd2147483647};

    always #10 clk = ~clk;

    vec_qrdmla_unit u_vec_qrdmla_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .lane32(lane32),
        .sub_mode(sub_mode), .opr_bytes(opr_bytes), .max_bytes(max_bytes),
        .src_a(src_a), .src_b(src_b), .dst_in(dst_in), .sat_clear(sat_clear),
        .out_valid(out_valid), .result(result), .sat_flag(sat_flag)
    );

    task automatic check(bit ok, string req, logic [VW-1:0] act, logic [VW-1:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Exact integer model of one lane
    function automatic longint lane_model(longint x, longint y, longint acc,
                                          int lw, bit sub, output bit sat);
        int s = lw - 1;
        longint hi = (longint'(1) <<< s) - 1;
        longint lo = -(longint'(1) <<< s);
        longint t = (acc <<< s) + (sub ? -(x * y) : (x * y)) + (longint'(1) <<< (s - 1));
        t = t >>> s;
        sat = 1'b0;
        if (t > hi) begin sat = 1'b1; t = hi; end
        else if (t < lo) begin sat = 1'b1; t = lo; end
        return t;
    endfunction

    function automatic logic [VW-1:0] build_exp(bit l32, bit sub, int opr, int mx,
            logic [VW-1:0] a, logic [VW-1:0] b, logic [VW-1:0] acc, output bit sat_any);
        logic [VW-1:0] e;
        bit s;
        longint r;
        sat_any = 1'b0;
        e = acc;
        for (int c = 0; c < VW/64; c++) begin
            if (c*8 < opr) begin
                if (l32) begin
                    for (int k = 2*c; k < 2*c + 2; k++) begin
                        r = lane_model(longint'($signed(a[32*k +: 32])), longint'($signed(b[32*k +: 32])),
                                       longint'($signed(acc[32*k +: 32])), 32, sub, s);
                        e[32*k +: 32] = 32'(r);
                        sat_any |= s;
                    end
                end else begin
                    for (int i = 4*c; i < 4*c + 4; i++) begin
                        r = lane_model(longint'($signed(a[16*i +: 16])), longint'($signed(b[16*i +: 16])),
                                       longint'($signed(acc[16*i +: 16])), 16, sub, s);
                        e[16*i +: 16] = 16'(r);
                        sat_any |= s;
                    end
                end
            end else if (c*8 < mx) begin
                e[64*c +: 64] = '0;
            end
        end
        return e;
    endfunction

    task automatic drive(bit l32, bit sub, int opr, int mx,
                         logic [VW-1:0] a, logic [VW-1:0] b, logic [VW-1:0] acc);
        @(negedge clk);
        lane32 = l32; sub_mode = sub; opr_bytes = 5'(opr); max_bytes = 5'(mx);
        src_a = a; src_b = b; dst_in = acc; in_valid = 1'b1;
    endtask

    // One request, result and flag compared after the two-cycle latency
    task automatic run_op(bit l32, bit sub, int opr, int mx,
                          logic [VW-1:0] a, logic [VW-1:0] b, logic [VW-1:0] acc, string tag);
        logic [VW-1:0] e;
        bit sa;
        e = build_exp(l32, sub, opr, mx, a, b, acc, sa);
        drive(l32, sub, opr, mx, a, b, acc);
        @(negedge clk);
        in_valid = 1'b0;
        src_a = ~src_a;
        @(negedge clk);
        exp_flag |= sa;
        check(out_valid == 1'b1, "R9 out_valid", VW'(out_valid), VW'(1));
        check(result == e, tag, result, e);
        check(sat_flag == exp_flag, "R6 sticky flag", VW'(sat_flag), VW'(exp_flag));
    endtask

    task automatic clear_flag();
        @(negedge clk);
        sat_clear = 1'b1;
        @(negedge clk);
        sat_clear = 1'b0;
        exp_flag = 1'b0;
        check(sat_flag == 1'b0, "R7 clear", VW'(sat_flag), VW'(0));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        nerr++;
        nchk++;
        $display("FAIL R9 watchdog expired act=%0d exp=%0d", 0, 1);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin : main
        logic [VW-1:0] a, b, c, e1, e2, hold;
        bit sa;

        // R10: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R10 out_valid", VW'(out_valid), VW'(0));
        check(sat_flag == 1'b0, "R10 sat_flag", VW'(sat_flag), VW'(0));
        check(result == '0, "R10 result", result, '0);

        // R1/R3/R4/R5: 16-bit sweep over corner triples, both modes
        for (int sm = 0; sm < 2; sm++) begin
            for (int x = 0; x < 8; x++) begin
                for (int y = 0; y < 8; y++) begin
                    for (int j = 0; j < 8; j++) begin
                        a[16*j +: 16] = 16'(v16[x]);
                        b[16*j +: 16] = 16'(v16[(y + j) % 8]);
                        c[16*j +: 16] = 16'(v16[j]);
                    end
                    run_op(1'b0, sm[0], 16, 16, a, b, c, sm ? "R3 R4 R5 half sub" : "R1 R4 R5 half add");
                end
            end
        end

        // R2/R3/R4/R5: 32-bit sweep over corner triples, both modes
        for (int sm = 0; sm < 2; sm++) begin
            for (int x = 0; x < 8; x++) begin
                for (int y = 0; y < 8; y++) begin
                    for (int h = 0; h < 2; h++) begin
                        for (int k = 0; k < 4; k++) begin
                            a[32*k +: 32] = 32'(v32[x]);
                            b[32*k +: 32] = 32'(v32[(y + k) % 8]);
                            c[32*k +: 32] = 32'(v32[4*h + k]);
                        end
                        run_op(1'b1, sm[0], 16, 16, a, b, c, sm ? "R2 R3 R4 word sub" : "R2 R4 word add");
                    end
                end
            end
        end

        // Random operands with mixed size settings
        for (int n = 0; n < 150; n++) begin
            int o = 8 * $urandom_range(0, 2);
            int m = o + 8 * $urandom_range(0, (16 - o) / 8);
            a = {$urandom, $urandom, $urandom, $urandom};
            b = {$urandom, $urandom, $urandom, $urandom};
            c = {$urandom, $urandom, $urandom, $urandom};
            run_op(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), o, m, a, b, c, "R8 R1 R2 random");
        end

        // R7: clear, then R6: a saturating op holds the flag across idle cycles
        clear_flag();
        a = '0; b = '0; c = '0;
        a[15:0] = 16'h8000; b[15:0] = 16'h8000; c[15:0] = 16'h7FFF;
        run_op(1'b0, 1'b0, 16, 16, a, b, c, "R4 positive clamp");
        repeat (4) @(negedge clk);
        check(sat_flag == 1'b1, "R6 held", VW'(sat_flag), VW'(1));

        // R7: clear and set at the same edge, set wins
        clear_flag();
        e1 = build_exp(1'b0, 1'b0, 16, 16, a, b, c, sa);
        drive(1'b0, 1'b0, 16, 16, a, b, c);
        @(negedge clk);
        in_valid = 1'b0;
        sat_clear = 1'b1;
        @(negedge clk);
        sat_clear = 1'b0;
        check(out_valid == 1'b1, "R9 out_valid", VW'(out_valid), VW'(1));
        check(sat_flag == 1'b1, "R7 set beats clear", VW'(sat_flag), VW'(1));
        check(result == e1, "R4 result", result, e1);
        clear_flag();

        // R12 and R8: saturation only in a zeroed chunk
        a = '0; b = '0; c = '0;
        a[127:112] = 16'h8000; b[127:112] = 16'h8000; c[127:112] = 16'h7FFF;
        c[15:0] = 16'h1234;
        run_op(1'b0, 1'b0, 8, 16, a, b, c, "R8 R12 upper zeroed");
        check(sat_flag == 1'b0, "R12 no flag", VW'(sat_flag), VW'(0));
        // R12 and R8: saturation only in a pass-through chunk
        run_op(1'b0, 1'b0, 8, 8, a, b, c, "R8 R12 upper passes");
        check(sat_flag == 1'b0, "R12 no flag", VW'(sat_flag), VW'(0));
        // R8: nothing computed, everything zeroed
        run_op(1'b1, 1'b0, 0, 16, a, b, c, "R8 all zero");

        // R11: result held while no valid, with inputs changing
        hold = result;
        repeat (3) begin
            @(negedge clk);
            src_a = {$urandom, $urandom, $urandom, $urandom};
            dst_in = ~dst_in;
            check(out_valid == 1'b0, "R11 no valid", VW'(out_valid), VW'(0));
            check(result == hold, "R11 hold", result, hold);
        end

        // R9: back-to-back requests, one result per cycle
        a = {$urandom, $urandom, $urandom, $urandom};
        b = {$urandom, $urandom, $urandom, $urandom};
        c = {$urandom, $urandom, $urandom, $urandom};
        e1 = build_exp(1'b0, 1'b1, 16, 16, a, b, c, sa);
        e2 = build_exp(1'b1, 1'b0, 16, 16, c, a, b, sa);
        drive(1'b0, 1'b1, 16, 16, a, b, c);
        drive(1'b1, 1'b0, 16, 16, c, a, b);
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b1, "R9 first", VW'(out_valid), VW'(1));
        check(result == e1, "R9 R3 first result", result, e1);
        @(negedge clk);
        check(out_valid == 1'b1, "R9 second", VW'(out_valid), VW'(1));
        check(result == e2, "R9 R2 second result", result, e2);
        @(negedge clk);
        check(out_valid == 1'b0, "R9 drop", VW'(out_valid), VW'(0));

        // R10: reset mid-run clears flag and result
        a = '0; b = '0; c = '0;
        a[31:0] = 32'h80000000; b[31:0] = 32'h80000000; c[31:0] = 32'h7FFFFFFF;
        run_op(1'b1, 1'b0, 16, 16, a, b, c, "R4 R2 word clamp");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        exp_flag = 1'b0;
        check(sat_flag == 1'b0, "R10 flag after reset", VW'(sat_flag), VW'(0));
        check(result == '0, "R10 result after reset", result, '0);
        check(out_valid == 1'b0, "R10 valid after reset", VW'(out_valid), VW'(0));

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule